// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Word Variants

This block is the integer execute slice of a 64-bit register machine. Each cycle it may be issued one instruction word together with the two source register values and a 16-bit immediate. A small decode front end matches the instruction word against a table of mask/code pairs. It then turns it into a micro-operation: the function (add, subtract, shift left, logical shift right, arithmetic shift right), the operand width (full 64-bit or 32-bit word), whether the immediate replaces the first operand, and where the shift amount comes from.

Every arithmetic and shift operation has a word form. A word form computes on the low 32 bits and then copies bit 31 of the result into bits 63:32. Immediate shifts of the full register come in a plain form and a "high" form that adds 32 to the 5-bit amount, so all shift distances from 0 to 63 can be reached. Variable shifts take their distance from the first source register. The result is registered: it appears one cycle after issue together with a valid strobe. An unrecognised instruction word instead raises a single-cycle illegal flag and leaves the result at zero.

Top module: `alu64_exec`

## Requirements
- R1: Full-width add (code 0xea000000) returns src_a + src_b modulo 2^64, and full-width subtract (code 0xea000020) returns src_a - src_b modulo 2^64. Both codes are matched under mask 0xfe007fe0, so bits 24:15 and 4:0 of the instruction are don't-care.
- R2: Add-immediate returns the 16-bit immediate sign-extended to 64 bits plus src_b. Its full-width form matches 0x02000000 and its word form matches 0x04000000, both under mask 0xfe000000.
- R3: Word add (0xec000000), word subtract (0xec000020) and word add-immediate return the low 32 bits of the sum or difference, with bit 31 replicated into bits 63:32. Bits 63:32 of the sources have no effect on them.
- R4: Variable shifts shift src_b by an amount taken from src_a. Full-width forms use src_a[5:0]: left 0xea004020, logical right 0xea004040, arithmetic right 0xea004060. Word forms use src_a[4:0]: left 0xec004020, logical right 0xec004040, arithmetic right 0xec004060. All are matched under mask 0xfe007fe0.
- R5: Immediate shifts are matched under mask 0xfff07c00 and take their 5-bit amount from instruction bits 9:5. Full-width forms shift src_b by that amount: left 0xea005000, logical right 0xea006000, arithmetic right 0xea007000. High forms shift src_b by 32 plus that amount: left 0xec005400, logical right 0xec006400, arithmetic right 0xec007400.
- R6: Word right shifts (variable, or immediate at 0xec006000 logical / 0xec007000 arithmetic) act on src_b[31:0]. The logical form fills with zeros from bit 31 down. The arithmetic form fills with src_b[31]. The 32-bit outcome is then sign-extended from bit 31. The word immediate left shift is 0xec005000.
- R7: Full-width arithmetic right shifts, both variable and immediate, fill the vacated upper bits with src_b[63] and never behave as a logical shift.
- R8: Any instruction bits outside the mask of the matched form do not change the result.
- R9: An issued legal instruction produces result_o and a valid_o pulse on the clock edge that samples issue_i. Instructions issued on consecutive cycles give results on consecutive cycles.
- R10: An issued word that matches no table entry raises illegal_o for exactly one cycle, with valid_o low and result_o zero.
- R11: While rst_n is low, result_o, valid_o and illegal_o are all zero.
- R12: In a cycle after which issue_i was low, valid_o and illegal_o are low and result_o is zero, whatever the instruction and operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 64 | First source register value (also the variable shift amount) |
| src_b_i | input | 64 | Second source register value (the shifted value) |
| imm_i | input | 16 | Immediate, sign-extended inside the block |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result holds a legal instruction's outcome |
| illegal_o | output | 1 | Issued instruction matched no known encoding |

## Verification
Every path from decode to result passes through a single output register. A wrong table entry, a swapped operand or a broken shifter stage therefore shows at the ports exactly one cycle after the faulty instruction is issued. It appears as a wrong result, a misplaced valid/illegal flag, or upper bits that do not copy bit 31. The vectors use shift amounts that together set every bit of the six-bit amount. They pair each word form with source upper bits that would corrupt the result if they leaked in. This way a fault in one barrel stage or in the word pre-extension gives a differing value rather than one that matches by accident.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

   localparam int unsigned ILEN     = 32;
   localparam int unsigned SHAMT_W  = 5;
   localparam int unsigned SHAMT_LSB = 5;

   typedef enum logic [2:0] {
      FN_ADD = 3'd0,
      FN_SUB = 3'd1,
      FN_SHL = 3'd2,
      FN_SHR = 3'd3,
      FN_SAR = 3'd4
   } alu_fn_e;

   typedef enum logic [1:0] {
      AMT_REG = 2'd0,
      AMT_IMM = 2'd1,
      AMT_HI  = 2'd2
   } amt_src_e;

   typedef struct packed {
      logic     legal;
      alu_fn_e  fn;
      logic     word;
      logic     use_imm;
      amt_src_e amt;
   } uop_t;

   typedef struct packed {
      logic [ILEN-1:0] mask;
      logic [ILEN-1:0] code;
      uop_t            uop;
   } dec_entry_t;

   // match masks of the three instruction shapes
   localparam logic [ILEN-1:0] MSK_REGREG = 32'hfe007fe0;
   localparam logic [ILEN-1:0] MSK_SHIMM  = 32'hfff07c00;
   localparam logic [ILEN-1:0] MSK_ADDIMM = 32'hfe000000;

   function automatic dec_entry_t ent(input logic [ILEN-1:0] m,
                                      input logic [ILEN-1:0] c,
                                      input alu_fn_e         f,
                                      input logic            w,
                                      input logic            im,
                                      input amt_src_e        s);
      dec_entry_t e;
      e.mask        = m;
      e.code        = c;
      e.uop.legal   = 1'b1;
      e.uop.fn      = f;
      e.uop.word    = w;
      e.uop.use_imm = im;
      e.uop.amt     = s;
      return e;
   endfunction

   localparam int unsigned DEC_N = 21;

   // entries are mutually exclusive, so the scan order carries no priority
   localparam dec_entry_t DEC_TABLE [DEC_N] = '{
      ent(MSK_ADDIMM, 32'h02000000, FN_ADD, 1'b0, 1'b1, AMT_REG),
      ent(MSK_ADDIMM, 32'h04000000, FN_ADD, 1'b1, 1'b1, AMT_REG),
      ent(MSK_REGREG, 32'hea000000, FN_ADD, 1'b0, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hea000020, FN_SUB, 1'b0, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hec000000, FN_ADD, 1'b1, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hec000020, FN_SUB, 1'b1, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hea004020, FN_SHL, 1'b0, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hea004040, FN_SHR, 1'b0, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hea004060, FN_SAR, 1'b0, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hec004020, FN_SHL, 1'b1, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hec004040, FN_SHR, 1'b1, 1'b0, AMT_REG),
      ent(MSK_REGREG, 32'hec004060, FN_SAR, 1'b1, 1'b0, AMT_REG),
      ent(MSK_SHIMM,  32'hea005000, FN_SHL, 1'b0, 1'b0, AMT_IMM),
      ent(MSK_SHIMM,  32'hea006000, FN_SHR, 1'b0, 1'b0, AMT_IMM),
      ent(MSK_SHIMM,  32'hea007000, FN_SAR, 1'b0, 1'b0, AMT_IMM),
      ent(MSK_SHIMM,  32'hec005000, FN_SHL, 1'b1, 1'b0, AMT_IMM),
      ent(MSK_SHIMM,  32'hec006000, FN_SHR, 1'b1, 1'b0, AMT_IMM),
      ent(MSK_SHIMM,  32'hec007000, FN_SAR, 1'b1, 1'b0, AMT_IMM),
      ent(MSK_SHIMM,  32'hec005400, FN_SHL, 1'b0, 1'b0, AMT_HI),
      ent(MSK_SHIMM,  32'hec006400, FN_SHR, 1'b0, 1'b0, AMT_HI),
      ent(MSK_SHIMM,  32'hec007400, FN_SAR, 1'b0, 1'b0, AMT_HI)
   };

endpackage

// File: rtl/alu64_decode.sv
module alu64_decode
   import alu64_pkg::*;
(
   input  logic [ILEN-1:0]    insn_i,
   output uop_t               uop_o,
   output logic [SHAMT_W-1:0] shamt_o
);

   logic [DEC_N-1:0] hit;

   // one comparator per table row
   for (genvar i = 0; i < DEC_N; i++) begin : g_row
      assign hit[i] = ((insn_i & DEC_TABLE[i].mask) == DEC_TABLE[i].code);
   end

   always_comb begin
      uop_o = '0;
      for (int i = 0; i < DEC_N; i++) begin
         if (hit[i]) begin
            uop_o = DEC_TABLE[i].uop;
         end
      end
   end

   assign shamt_o = insn_i[SHAMT_LSB +: SHAMT_W];

endmodule

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
   parameter int unsigned XLEN      = 64,
   parameter bit          SPLIT_ADD = 1'b1
) (
   input  logic [XLEN-1:0] x_i,
   input  logic [XLEN-1:0] y_i,
   input  logic            sub_i,
   output logic [XLEN-1:0] sum_o
);

   localparam int unsigned HALF = XLEN / 2;

   logic [XLEN-1:0] y_eff;

   assign y_eff = sub_i ? ~y_i : y_i;

   if (SPLIT_ADD) begin : g_csel
      // low half ripples, high half is precomputed for both carries
      logic [HALF:0]        lo_sum;
      logic [XLEN-HALF-1:0] hi_c0;
      logic [XLEN-HALF-1:0] hi_c1;

      assign lo_sum = {1'b0, x_i[HALF-1:0]} + {1'b0, y_eff[HALF-1:0]}
                    + {{HALF{1'b0}}, sub_i};
      assign hi_c0  = x_i[XLEN-1:HALF] + y_eff[XLEN-1:HALF];
      assign hi_c1  = x_i[XLEN-1:HALF] + y_eff[XLEN-1:HALF]
                    + {{(XLEN-HALF-1){1'b0}}, 1'b1};
      assign sum_o  = {lo_sum[HALF] ? hi_c1 : hi_c0, lo_sum[HALF-1:0]};
   end else begin : g_flat
      assign sum_o = x_i + y_eff + {{(XLEN-1){1'b0}}, sub_i};
   end

endmodule

// File: rtl/alu64_shifter.sv
module alu64_shifter #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned WORD = 32
) (
   input  logic [XLEN-1:0]         val_i,
   input  logic [$clog2(XLEN)-1:0] amt_i,
   input  logic                    left_i,
   input  logic                    arith_i,
   input  logic                    word_i,
   output logic [XLEN-1:0]         res_o
);

   localparam int unsigned SHW = $clog2(XLEN);

   logic [XLEN-1:0] prep;
   logic [XLEN-1:0] prep_rev;
   logic [XLEN-1:0] out_rev;
   logic [XLEN-1:0] stage [0:SHW];
   logic            fill;

   // word right shifts see only the low word, zero- or sign-extended
   always_comb begin
      prep = val_i;
      if (word_i && !left_i) begin
         if (arith_i) begin
            prep = {{(XLEN-WORD){val_i[WORD-1]}}, val_i[WORD-1:0]};
         end else begin
            prep = {{(XLEN-WORD){1'b0}}, val_i[WORD-1:0]};
         end
      end
   end

   for (genvar i = 0; i < XLEN; i++) begin : g_rev
      assign prep_rev[i] = prep[XLEN-1-i];
      assign out_rev[i]  = stage[SHW][XLEN-1-i];
   end

   assign fill     = arith_i & ~left_i & prep[XLEN-1];
   assign stage[0] = left_i ? prep_rev : prep;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int unsigned D = 1 << k;
      assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][XLEN-1:D]} : stage[k];
   end

   assign res_o = left_i ? out_rev : stage[SHW];

endmodule

// File: rtl/alu64_exec.sv
module alu64_exec
   import alu64_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned WORD      = 32,
   parameter int unsigned IMM_W     = 16,
   parameter bit          SPLIT_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_i,
   input  logic [ILEN-1:0]  insn_i,
   input  logic [XLEN-1:0]  src_a_i,
   input  logic [XLEN-1:0]  src_b_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic [XLEN-1:0]  result_o,
   output logic             valid_o,
   output logic             illegal_o
);

   localparam int unsigned SHW  = $clog2(XLEN);
   localparam int unsigned WSHW = $clog2(WORD);

   if (XLEN != 2 * WORD) begin : g_bad_width
      $error("alu64_exec: XLEN must be twice WORD");
   end
   if (WSHW != SHAMT_W) begin : g_bad_shamt
      $error("alu64_exec: immediate shift field must cover one word");
   end
   if (IMM_W >= XLEN) begin : g_bad_imm
      $error("alu64_exec: immediate must be narrower than XLEN");
   end

   uop_t               uop;
   logic [SHAMT_W-1:0] shamt;
   logic [XLEN-1:0]    imm_ext;
   logic [XLEN-1:0]    add_x;
   logic [XLEN-1:0]    sum;
   logic [XLEN-1:0]    shout;
   logic [SHW-1:0]     amt;
   logic [XLEN-1:0]    raw;
   logic [XLEN-1:0]    res;
   logic               is_arith;

   alu64_decode u_dec (
      .insn_i  (insn_i),
      .uop_o   (uop),
      .shamt_o (shamt)
   );

   assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
   assign add_x   = uop.use_imm ? imm_ext : src_a_i;

   alu64_addsub #(
      .XLEN      (XLEN),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_add (
      .x_i   (add_x),
      .y_i   (src_b_i),
      .sub_i (uop.fn == FN_SUB),
      .sum_o (sum)
   );

   always_comb begin
      unique case (uop.amt)
         AMT_REG: amt = uop.word ? SHW'(src_a_i[WSHW-1:0]) : src_a_i[SHW-1:0];
         AMT_IMM: amt = SHW'(shamt);
         AMT_HI:  amt = SHW'(WORD) + SHW'(shamt);
         default: amt = '0;
      endcase
   end

   alu64_shifter #(
      .XLEN (XLEN),
      .WORD (WORD)
   ) u_shf (
      .val_i   (src_b_i),
      .amt_i   (amt),
      .left_i  (uop.fn == FN_SHL),
      .arith_i (uop.fn == FN_SAR),
      .word_i  (uop.word),
      .res_o   (shout)
   );

   assign is_arith = (uop.fn == FN_ADD) || (uop.fn == FN_SUB);
   assign raw      = is_arith ? sum : shout;
   assign res      = uop.word ? {{(XLEN-WORD){raw[WORD-1]}}, raw[WORD-1:0]} : raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o  <= '0;
         valid_o   <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         valid_o   <= issue_i & uop.legal;
         illegal_o <= issue_i & ~uop.legal;
         result_o  <= (issue_i && uop.legal) ? res : '0;
      end
   end

endmodule

// File: rtl/alu64_exec_chk.sv
module alu64_exec_chk #(
   parameter int unsigned XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            issue_i,
   input logic [31:0]     insn_i,
   input logic [XLEN-1:0] src_a_i,
   input logic [XLEN-1:0] src_b_i,
   input logic [XLEN-1:0] result_o,
   input logic            valid_o,
   input logic            illegal_o
);

   logic is_add64;
   logic is_word;
   logic is_sar64;
   logic shimm_grp;

   assign is_add64  = (insn_i & 32'hfe007fe0) == 32'hea000000;
   assign shimm_grp = (insn_i[31:25] == 7'h76) && (insn_i[14:12] >= 3'd5);
   assign is_word   = (insn_i[31:25] == 7'h02) ||
                      ((insn_i[31:25] == 7'h76) && !(shimm_grp && insn_i[10]));
   assign is_sar64  = ((insn_i & 32'hfe007fe0) == 32'hea004060) ||
                      ((insn_i & 32'hfff07c00) == 32'hea007000) ||
                      ((insn_i & 32'hfff07c00) == 32'hec007400);

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) illegal_o |-> (result_o == '0) && !valid_o); // R10
   AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) !$past(issue_i) |-> !valid_o && !illegal_o); // R12
   AST_IDLE_ZERO_RES: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> result_o == '0); // R12
   AST_ADD_FULL: assert property (@(posedge clk) disable iff (!rst_n) valid_o && $past(is_add64) |-> result_o == $past(src_a_i + src_b_i)); // R1
   AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n) valid_o && $past(is_word) |-> result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}}); // R3
   AST_SAR_SIGN: assert property (@(posedge clk) disable iff (!rst_n) valid_o && $past(is_sar64) && $past(src_b_i[XLEN-1]) |-> result_o[XLEN-1]); // R7

endmodule

bind alu64_exec alu64_exec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_alu64_exec.sv
module test_alu64_exec;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 5000;

   typedef struct packed {
      logic [31:0] insn;
      logic [63:0] a;
      logic [63:0] b;
      logic [15:0] imm;
      logic [63:0] exp;
      logic        ill;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 28;

   localparam vec_t VECS [NV] = '{
      '{32'hea000000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 16'h0, 64'h1, 1'b0, 8'd1},                                       // R1 wrap
      '{32'hea000000, 64'h8000_0000, 64'h8000_0000, 16'h0, 64'h1_0000_0000, 1'b0, 8'd1},                             // R1 carry into bit 32
      '{32'hea000020, 64'h5, 64'h7, 16'h0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 8'd1},                                     // R1 borrow
      '{32'hec000000, 64'h7FFF_FFFF, 64'h1, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd3},                             // R3 word add sext
      '{32'hec000020, 64'h1_0000_0005, 64'h3, 16'h0, 64'h2, 1'b0, 8'd3},                                             // R3 upper ignored
      '{32'h02000000, 64'h0, 64'h1_0000_0000, 16'hFFFF, 64'hFFFF_FFFF, 1'b0, 8'd2},                                  // R2 negative imm
      '{32'h04000000, 64'h0, 64'h7FFF_8001, 16'h7FFF, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd2},                          // R2 word imm
      '{32'hea004020, 64'h44, 64'h1, 16'h0, 64'h10, 1'b0, 8'd4},                                                     // R4 low six bits
      '{32'hea004040, 64'd63, 64'h8000_0000_0000_0000, 16'h0, 64'h1, 1'b0, 8'd4},                                    // R4 max distance
      '{32'hea004060, 64'd60, 64'h8000_0000_0000_0000, 16'h0, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 8'd7},                  // R7 variable sar
      '{32'hec004020, 64'h21, 64'h4000_0000, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd4},                            // R4 word low five
      '{32'hec004040, 64'h4, 64'hFFFF_FFFF_8000_0000, 16'h0, 64'h0800_0000, 1'b0, 8'd6},                             // R6 word srl
      '{32'hec004060, 64'h4, 64'h8000_0000, 16'h0, 64'hFFFF_FFFF_F800_0000, 1'b0, 8'd6},                             // R6 word sra
      '{32'hec004040, 64'h20, 64'h8000_0001, 16'h0, 64'hFFFF_FFFF_8000_0001, 1'b0, 8'd6},                            // R6 zero distance
      '{32'hea005100, 64'h0, 64'hFF, 16'h0, 64'hFF00, 1'b0, 8'd5},                                                   // R5 imm sll
      '{32'hec005480, 64'h0, 64'h1, 16'h0, 64'h10_0000_0000, 1'b0, 8'd5},                                            // R5 sll by 36
      '{32'hec0067E0, 64'h0, 64'h8000_0000_0000_0000, 16'h0, 64'h1, 1'b0, 8'd5},                                     // R5 srl by 63
      '{32'hec007400, 64'h0, 64'h8000_0000_0000_0000, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd7},                   // R7 sra by 32
      '{32'hea007020, 64'h0, 64'hF000_0000_0000_0000, 16'h0, 64'hF800_0000_0000_0000, 1'b0, 8'd7},                   // R7 imm sar
      '{32'hea006080, 64'h0, 64'hF0, 16'h0, 64'hF, 1'b0, 8'd5},                                                      // R5 imm srl
      '{32'hec006020, 64'h0, 64'h8000_0000, 16'h0, 64'h4000_0000, 1'b0, 8'd6},                                       // R6 word imm srl
      '{32'hec007020, 64'h0, 64'h1234_5678_8000_0000, 16'h0, 64'hFFFF_FFFF_C000_0000, 1'b0, 8'd6},                   // R6 word imm sra
      '{32'hec0053E0, 64'h0, 64'h3, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd3},                                     // R3 word imm sll
      '{32'hEBFF801F, 64'h1, 64'h2, 16'h0, 64'h3, 1'b0, 8'd8},                                                       // R8 register fields set
      '{32'hea001000, 64'h1, 64'h2, 16'h0, 64'h0, 1'b1, 8'd10},                                                      // R10 unknown
      '{32'h00000000, 64'h1, 64'h2, 16'h0, 64'h0, 1'b1, 8'd10},                                                      // R10 all zero
      '{32'hec105000, 64'h0, 64'h1, 16'h0, 64'h0, 1'b1, 8'd10},                                                      // R10 masked field set
      '{32'hea004000, 64'h0, 64'h1, 16'h0, 64'h0, 1'b1, 8'd10}                                                       // R10 gap code
   };

   logic        clk;
   logic        rst_n;
   logic        issue_i;
   logic [31:0] insn_i;
   logic [63:0] src_a_i;
   logic [63:0] src_b_i;
   logic [15:0] imm_i;
   logic [63:0] result_o;
   logic        valid_o;
   logic        illegal_o;

   int n_vec;
   int n_bad;

   alu64_exec i_alu64_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_i   (issue_i),
      .insn_i    (insn_i),
      .src_a_i   (src_a_i),
      .src_b_i   (src_b_i),
      .imm_i     (imm_i),
      .result_o  (result_o),
      .valid_o   (valid_o),
      .illegal_o (illegal_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check_out(input int req, input logic [63:0] exp_res,
                            input logic exp_val, input logic exp_ill);
      n_vec++;
      if ({illegal_o, valid_o, result_o} !== {exp_ill, exp_val, exp_res}) begin
         n_bad++;
         $display("FAIL R%0d: got res=%h val=%b ill=%b, expected res=%h val=%b ill=%b",
                  req, result_o, valid_o, illegal_o, exp_res, exp_val, exp_ill);
      end
   endtask

   task automatic drive(input vec_t v);
      insn_i  = v.insn;
      src_a_i = v.a;
      src_b_i = v.b;
      imm_i   = v.imm;
      issue_i = 1'b1;
   endtask

   task automatic run_vec(input vec_t v);
      drive(v);
      @(negedge clk);
      issue_i = 1'b0;
      check_out(int'(v.req), v.exp, !v.ill, v.ill);
   endtask

   initial begin
      repeat (WDOG_LIMIT) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got no end, expected finish within %0d cycles", WDOG_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      n_vec   = 0;
      n_bad   = 0;
      rst_n   = 1'b0;
      issue_i = 1'b0;
      insn_i  = '0;
      src_a_i = '0;
      src_b_i = '0;
      imm_i   = '0;
      repeat (3) @(negedge clk);
      check_out(11, 64'h0, 1'b0, 1'b0);                 // R11 reset state
      rst_n = 1'b1;
      @(negedge clk);
      check_out(12, 64'h0, 1'b0, 1'b0);                 // R12 idle after reset

      for (int i = 0; i < NV; i++) begin
         run_vec(VECS[i]);
      end

      // R10: illegal flag lasts one cycle only
      run_vec(VECS[24]);
      @(negedge clk);
      check_out(10, 64'h0, 1'b0, 1'b0);

      // R9: back-to-back issue gives results on consecutive cycles
      drive(VECS[0]);
      @(negedge clk);
      check_out(9, 64'h1, 1'b1, 1'b0);
      drive(VECS[3]);
      @(negedge clk);
      check_out(9, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
      drive(VECS[25]);
      @(negedge clk);
      issue_i = 1'b0;
      check_out(9, 64'h0, 1'b0, 1'b1);

      // R12: inputs without issue leave the outputs quiet
      insn_i  = 32'hea000000;
      src_a_i = 64'h1234;
      src_b_i = 64'h1;
      @(negedge clk);
      check_out(12, 64'h0, 1'b0, 1'b0);
      insn_i = 32'h0;
      @(negedge clk);
      check_out(12, 64'h0, 1'b0, 1'b0);

      // R11: reset clears a result that was just produced
      drive(VECS[2]);
      @(negedge clk);
      issue_i = 1'b0;
      check_out(1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0);
      drive(VECS[2]);
      rst_n = 1'b0;
      @(negedge clk);
      issue_i = 1'b0;
      check_out(11, 64'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule